// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block sits between a processor's memory-access stage and a slower, word-wide main memory. It keeps 16 lines of 4 words each, indexed directly from the word address, so every address has exactly one line it can live in. Loads that find their word in the cache return it in the same cycle. Loads that miss hold the processor while the whole block is fetched from memory in offset order.

Every store is sent to main memory as it completes, so memory never holds stale data. A store that misses first brings the block into the cache and then writes the word into both the line and memory. When memory acknowledges each request in the cycle it is made, a load miss costs a fixed 8 stall cycles and a store miss a fixed 9. A slower memory stretches the stall until the block is complete.

The processor keeps its address, strobes and write data steady for as long as the stall output is high. The access completes in the first cycle the stall output is low.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid. With no request pending, the stall output and the memory request are both low, and the first access to any address misses.
- R2: The 8-bit word address splits into a word offset in bits [1:0], a line index in bits [5:2] and a tag in bits [7:6]. An access hits only when its line is valid and the stored tag matches. Two addresses that differ only in the offset share a block.
- R3: A load that hits returns the cached word in the same cycle with the stall output low, and issues no memory request.
- R4: With memory acknowledging in the request cycle, a load miss holds the stall output high for exactly 8 consecutive cycles, starting with the cycle the load is presented. The correct word is on the read-data output in the cycle the stall output drops.
- R5: A fill issues exactly 4 memory reads with the write strobe low. The addresses are {tag, index, offset} with the offset running 0, 1, 2, 3 in that order.
- R6: With memory acknowledging in the request cycle, a store miss holds the stall output high for exactly 9 cycles. It fills the block with 4 reads, after which loads to that block hit.
- R7: Every store writes its data to its address in main memory exactly once, in the cycle the store completes. A store hit with an acknowledging memory does not stall.
- R8: A store hit also updates the cached word, so a later load of that address hits and returns the new value with no memory access.
- R9: An access to a line that holds a different tag misses and replaces the block. A later access to the evicted block misses again.
- R10: When memory takes L extra cycles to acknowledge, a miss stalls for the larger of its fixed latency and 1+4(L+1) cycles. A store additionally waits L cycles for its write acknowledge. Data stays correct in all cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 8 | Word address of the access |
| cpu_rd | input | 1 | Load strobe |
| cpu_wr | input | 1 | Store strobe (wins if both are high) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while the stall output is low |
| cpu_stall | output | 1 | Processor must hold its request while high |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with the acknowledge |
| mem_ack | input | 1 | Memory acknowledge for the current request |

## Verification
A load hit's data and a zero stall are due in the cycle the load is presented. A miss's data is due in the cycle the stall output first reads low, which is 8 or 9 cycles later at zero memory latency. The memory write of a store lands at the rising edge that closes the access. The bench drives each request just after a falling edge, samples one time unit later and counts one stall cycle per low clock phase in which the stall output is high. It reads data when the stall output is first seen low, and checks the memory model and its read-address log only after the following rising edge has passed. Expected stall counts come from a shadow tag table kept in the bench and the memory latency it has chosen.

// File: rtl/dc_pkg.sv
package dc_pkg;

  // Miss-handling controller states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // serve hits, detect misses
    ST_FILL = 2'd1,   // fetch block words from memory
    ST_PAD  = 2'd2    // hold stall until fixed latency is reached
  } dc_state_e;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int TAG_W = 2,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [TAG_W-1:0] up_tag
);

  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  // per-line next state and storage
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic line_we;
    assign line_we = up_en && (up_idx == IDX_W'(g));

    always_comb begin
      valid_d[g] = valid_q[g];
      if (line_we) begin
        valid_d[g] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else begin
        valid_q[g] <= valid_d[g];
      end
    end

    always_ff @(posedge clk) begin
      if (line_we) begin
        tag_q[g] <= up_tag;
      end
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);

  localparam int ENTRIES = (1 << IDX_W) * (1 << OFF_W);
  localparam int SEL_W   = IDX_W + OFF_W;

  logic [DATA_W-1:0] word_q [ENTRIES];
  logic [SEL_W-1:0]  wr_sel;
  logic [SEL_W-1:0]  rd_sel;

  assign wr_sel = {wr_idx, wr_off};
  assign rd_sel = {rd_idx, rd_off};

  // storage words carry no reset; validity lives in the tag store
  for (genvar g = 0; g < ENTRIES; g++) begin : g_word
    logic word_we;
    assign word_we = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (word_we) begin
        word_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = word_q[rd_sel];

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int TAG_W       = 2,
  parameter int IDX_W       = 4,
  parameter int OFF_W       = 2,
  parameter int RD_MISS_CYC = 8,
  parameter int WR_MISS_CYC = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]   cpu_addr,
  input  logic                           cpu_rd,
  input  logic                           cpu_wr,
  input  logic [DATA_W-1:0]              cpu_wdata,
  output logic                           cpu_stall,
  input  logic                           lk_hit,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]              mem_wdata,
  input  logic [DATA_W-1:0]              mem_rdata,
  input  logic                           mem_ack,
  output logic                           dw_en,
  output logic [IDX_W-1:0]               dw_idx,
  output logic [OFF_W-1:0]               dw_off,
  output logic [DATA_W-1:0]              dw_data,
  output logic                           tw_en,
  output logic [IDX_W-1:0]               tw_idx,
  output logic [TAG_W-1:0]               tw_tag
);

  localparam int ADDR_W  = TAG_W + IDX_W + OFF_W;
  localparam int BLK_W   = TAG_W + IDX_W;
  localparam int MAX_CYC = (RD_MISS_CYC > WR_MISS_CYC) ? RD_MISS_CYC : WR_MISS_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LIM  = CNT_W'(RD_MISS_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LIM  = CNT_W'(WR_MISS_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_CYC);
  localparam logic [OFF_W-1:0] LAST_OFF = '1;

  dc_state_e         st_q, st_d;
  logic [BLK_W-1:0]  blk_q;
  logic              wmiss_q;
  logic              cap_en;
  logic [OFF_W-1:0]  word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  lim;
  logic [CNT_W-1:0]  cnt_inc;
  logic              req;

  assign req     = cpu_rd || cpu_wr;
  assign lim     = wmiss_q ? WR_LIM : RD_LIM;
  assign cnt_inc = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;

  // next-state and output logic
  always_comb begin
    st_d      = st_q;
    word_d    = word_q;
    cnt_d     = cnt_q;
    cap_en    = 1'b0;
    cpu_stall = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {blk_q, word_q};
    mem_wdata = cpu_wdata;
    dw_en     = 1'b0;
    dw_idx    = blk_q[IDX_W-1:0];
    dw_off    = word_q;
    dw_data   = mem_rdata;
    tw_en     = 1'b0;
    tw_idx    = blk_q[IDX_W-1:0];
    tw_tag    = blk_q[BLK_W-1:IDX_W];
    unique case (st_q)
      ST_IDLE: begin
        if (req && !lk_hit) begin
          cpu_stall = 1'b1;
          cap_en    = 1'b1;
          word_d    = '0;
          cnt_d     = CNT_W'(1);
          st_d      = ST_FILL;
        end else if (cpu_wr) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = cpu_addr;
          cpu_stall = !mem_ack;
          dw_en     = mem_ack;
          dw_idx    = cpu_addr[OFF_W+IDX_W-1:OFF_W];
          dw_off    = cpu_addr[OFF_W-1:0];
          dw_data   = cpu_wdata;
        end
      end
      ST_FILL: begin
        cpu_stall = 1'b1;
        mem_req   = 1'b1;
        cnt_d     = cnt_inc;
        if (mem_ack) begin
          dw_en  = 1'b1;
          word_d = word_q + 1'b1;
          if (word_q == LAST_OFF) begin
            tw_en = 1'b1;
            st_d  = (cnt_q >= lim) ? ST_IDLE : ST_PAD;
          end
        end
      end
      ST_PAD: begin
        cpu_stall = 1'b1;
        cnt_d     = cnt_inc;
        if (cnt_q >= lim) begin
          st_d = ST_IDLE;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  // miss context, loaded only when a miss is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= '0;
      wmiss_q <= 1'b0;
    end else if (cap_en) begin
      blk_q   <= cpu_addr[ADDR_W-1:OFF_W];
      wmiss_q <= cpu_wr;
    end
  end

  // fill walks the block offsets upward
  AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && mem_ack && word_q != LAST_OFF) |=>
      (mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1))); // R5

  AST_FILL_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> !mem_we); // R5

  AST_STORE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_stall) |->
      (mem_req && mem_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata)); // R7

  AST_RDHIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && !cpu_stall) |-> !mem_req); // R3

endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int DATA_W      = 32,
  parameter int TAG_W       = 2,
  parameter int IDX_W       = 4,
  parameter int OFF_W       = 2,
  parameter int RD_MISS_CYC = 8,
  parameter int WR_MISS_CYC = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
  input  logic                         cpu_rd,
  input  logic                         cpu_wr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         cpu_stall,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata,
  input  logic                         mem_ack
);

  localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  logic [IDX_W-1:0]  cpu_idx;
  logic [TAG_W-1:0]  cpu_tag;
  logic [OFF_W-1:0]  cpu_off;
  logic              lk_hit;
  logic              dw_en;
  logic [IDX_W-1:0]  dw_idx;
  logic [OFF_W-1:0]  dw_off;
  logic [DATA_W-1:0] dw_data;
  logic              tw_en;
  logic [IDX_W-1:0]  tw_idx;
  logic [TAG_W-1:0]  tw_tag;

  assign cpu_off = cpu_addr[OFF_W-1:0];
  assign cpu_idx = cpu_addr[OFF_W+IDX_W-1:OFF_W];
  assign cpu_tag = cpu_addr[ADDR_W-1:OFF_W+IDX_W];

  dc_tag_store #(
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
  ) u_tags (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .lk_idx (cpu_idx),
    .lk_tag (cpu_tag),
    .lk_hit (lk_hit),
    .up_en  (tw_en),
    .up_idx (tw_idx),
    .up_tag (tw_tag)
  );

  dc_data_store #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
  ) u_data (
    .clk     (clk),
    .wr_en   (dw_en),
    .wr_idx  (dw_idx),
    .wr_off  (dw_off),
    .wr_data (dw_data),
    .rd_idx  (cpu_idx),
    .rd_off  (cpu_off),
    .rd_data (cpu_rdata)
  );

  dc_ctrl #(
    .DATA_W      (DATA_W),
    .TAG_W       (TAG_W),
    .IDX_W       (IDX_W),
    .OFF_W       (OFF_W),
    .RD_MISS_CYC (RD_MISS_CYC),
    .WR_MISS_CYC (WR_MISS_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_stall (cpu_stall),
    .lk_hit    (lk_hit),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .dw_en     (dw_en),
    .dw_idx    (dw_idx),
    .dw_off    (dw_off),
    .dw_data   (dw_data),
    .tw_en     (tw_en),
    .tw_idx    (tw_idx),
    .tw_tag    (tw_tag)
  );

  // a lookup that misses must hold the processor
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((cpu_rd || cpu_wr) && !lk_hit) |-> cpu_stall); // R2

  // releasing a miss means the block is now resident
  AST_HIT_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n_int)
    ($fell(cpu_stall) && (cpu_rd || cpu_wr)) |-> lk_hit); // R6

endmodule

// File: tb/sim_dcache_wt.sv
module sim_dcache_wt;

  localparam int CLK_PERIOD = 10;
  localparam int RD_FIX = 8;
  localparam int WR_FIX = 9;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cpu_addr;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [31:0] cpu_wdata;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req;
  logic        mem_we;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;

  dcache_wt u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] pat(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'hC3, b, ~b, b + 8'h5A};
  endfunction

  // main memory model with configurable acknowledge latency
  int          lat;
  int          wcnt;
  logic [31:0] mainmem [256];
  int          rd_total;
  int          wr_total;
  logic [7:0]  rlast [4];

  assign mem_ack   = mem_req && (wcnt == lat);
  assign mem_rdata = mainmem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) mainmem[a] <= pat(a);
      wcnt     <= 0;
      rd_total <= 0;
      wr_total <= 0;
    end else begin
      if (mem_req && !mem_ack) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (mem_req && mem_ack && mem_we) begin
        mainmem[mem_addr] <= mem_wdata;
        wr_total <= wr_total + 1;
      end
      if (mem_req && mem_ack && !mem_we) begin
        rd_total <= rd_total + 1;
        rlast[0] <= rlast[1];
        rlast[1] <= rlast[2];
        rlast[2] <= rlast[3];
        rlast[3] <= mem_addr;
      end
    end
  end

  // bench-side reference
  logic [31:0] refmem [256];
  bit          bvalid [16];
  logic [1:0]  btag [16];
  int          n_chk;
  int          n_fail;
  bit          done;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one access; returns the measured stall count
  task automatic access(input bit is_wr, input logic [7:0] a,
                        input logic [31:0] d, output int n);
    int  exp_n;
    int  fill_n;
    int  rd0;
    int  wr0;
    bit  hit;
    logic [3:0] idx;
    logic [1:0] tg;
    string sreq;
    idx    = a[5:2];
    tg     = a[7:6];
    hit    = bvalid[idx] && (btag[idx] == tg);
    fill_n = 1 + 4 * (lat + 1);
    if (hit) exp_n = is_wr ? lat : 0;
    else begin
      exp_n = is_wr ? WR_FIX : RD_FIX;
      if (fill_n > exp_n) exp_n = fill_n;
      if (is_wr) exp_n += lat;
    end
    if (lat > 0) sreq = "R10";
    else if (hit) sreq = is_wr ? "R7" : "R3";
    else sreq = is_wr ? "R6" : "R4";
    rd0 = rd_total;
    wr0 = wr_total;
    @(negedge clk);
    cpu_addr  = a;
    cpu_rd    = !is_wr;
    cpu_wr    = is_wr;
    cpu_wdata = d;
    #1;
    n = 0;
    while (cpu_stall && n < 300) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk(n == exp_n, sreq, "stall cycles", n, exp_n);
    if (!is_wr)
      chk(cpu_rdata == refmem[a], hit ? "R3" : "R4", "load data", cpu_rdata, refmem[a]);
    @(posedge clk);
    #1;
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
    chk((rd_total - rd0) == (hit ? 0 : 4), hit ? "R3" : "R5", "memory reads",
        rd_total - rd0, hit ? 0 : 4);
    if (!hit) begin
      for (int k = 0; k < 4; k++)
        chk(rlast[k] == {a[7:2], 2'(k)}, "R5", "fill order", rlast[k], {a[7:2], 2'(k)});
    end
    chk((wr_total - wr0) == (is_wr ? 1 : 0), "R7", "memory writes",
        wr_total - wr0, is_wr ? 1 : 0);
    if (is_wr) begin
      chk(mainmem[a] == d, "R7", "memory word", mainmem[a], d);
      refmem[a] = d;
    end
    if (!hit) begin
      bvalid[idx] = 1'b1;
      btag[idx]   = tg;
    end
  endtask

  initial begin
    int n;
    n_chk = 0; n_fail = 0; done = 1'b0; lat = 0;
    cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
    for (int a = 0; a < 256; a++) refmem[a] = pat(a);
    for (int i = 0; i < 16; i++) begin bvalid[i] = 1'b0; btag[i] = '0; end
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    chk(cpu_stall == 1'b0, "R1", "idle stall", cpu_stall, 0);
    chk(mem_req == 1'b0, "R1", "idle request", mem_req, 0);

    // first ever access misses
    access(1'b0, 8'h00, '0, n);
    chk(n == RD_FIX, "R1", "first access misses", n, RD_FIX);
    // offset bits share a block, index bits do not
    access(1'b0, 8'h03, '0, n);
    chk(n == 0, "R2", "same block hits", n, 0);
    access(1'b0, 8'h04, '0, n);
    chk(n == RD_FIX, "R2", "next index misses", n, RD_FIX);

    // load sweep over the whole address space
    for (int a = 0; a < 256; a++) access(1'b0, 8'(a), '0, n);

    // store sweep, every third word, mixed hits and misses
    for (int a = 0; a < 256; a += 3) access(1'b1, 8'(a), 32'hD00D_0000 + 32'(a * 7), n);

    // store hit then load the same word
    access(1'b1, 8'hF1, 32'h1234_5678, n);
    access(1'b0, 8'hF1, '0, n);
    chk(n == 0 && cpu_rdata == 32'h1234_5678, "R8", "load after store hit",
        cpu_rdata, 32'h1234_5678);

    // eviction by a conflicting tag
    access(1'b0, 8'h05, '0, n);
    access(1'b0, 8'h45, '0, n);
    chk(n == RD_FIX, "R9", "conflicting tag misses", n, RD_FIX);
    access(1'b0, 8'h06, '0, n);
    chk(n == RD_FIX, "R9", "evicted block misses again", n, RD_FIX);

    // store miss allocates the block
    access(1'b1, 8'h8A, 32'hCAFE_0001, n);
    chk(n == WR_FIX, "R6", "store miss stall", n, WR_FIX);
    access(1'b0, 8'h89, '0, n);
    chk(n == 0, "R6", "block resident after store miss", n, 0);

    // descending load sweep checks every word against the model
    for (int a = 255; a >= 0; a--) access(1'b0, 8'(a), '0, n);

    // slow memory
    lat = 2;
    access(1'b0, 8'h10, '0, n);
    access(1'b0, 8'h50, '0, n);
    access(1'b1, 8'h52, 32'h0BAD_F00D, n);
    access(1'b1, 8'hD3, 32'h5EED_0042, n);
    access(1'b0, 8'h52, '0, n);
    access(1'b0, 8'hD3, '0, n);
    lat = 0;
    for (int a = 0; a < 256; a += 5) access(1'b0, 8'(a), '0, n);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule